// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Carry Chaining

This unit performs the byte-wide arithmetic and logic step of a small microcontroller datapath. Each operation takes two operands. One is the destination register value. The other is either a second register value or an 8-bit constant from the instruction. The unit also takes the current carry flag. It returns the byte to write back over the destination, the new carry, zero and negative flags, and a write-enable for the register file. The operation is chosen by a 5-bit code.

Add and subtract each have a form that takes in the incoming carry or borrow. Multi-byte sums and differences are built by running the low byte first and then feeding the carry flag back in for the next byte. Clear, set-all, test, set-bits and clear-bits reuse the logic functions with fixed or self operands. Every operation is sampled on a clock edge when `op_valid` is high. Its results are held in registers and appear in the following cycle.

Top module: `byte_alu_unit`

## Requirements
- R1: When `op_valid` is high at a rising edge, the outputs show that operation's results from the next cycle on, with `out_valid` high for that one cycle. When `op_valid` is low at an edge, `out_valid` and `wr_en` go low in the next cycle, and `result` and the three flag outputs keep their values.
- R2: While `rst` is high at a rising edge, all outputs are cleared to zero in the following cycle, whatever `op_valid` carries.
- R3: Add (code 0) gives dst+src. Add-with-carry (code 1) gives dst+src+carry_in. In both, carry_out is bit 8 of the 9-bit sum.
- R4: Subtract (code 2) gives dst−src. Subtract-with-carry (code 3) gives dst−src−carry_in. In both, carry_out is set when a borrow occurs, meaning the true difference is below zero.
- R5: Immediate subtract (code 4) and immediate subtract-with-carry (code 5) behave like codes 2 and 3, with `imm_in` in place of `src_in`.
- R6: AND (6), OR (7) and XOR (8) combine dst with src. Immediate AND (9) and immediate OR (10) combine dst with imm. All five leave carry_out equal to carry_in.
- R7: One's complement (11) gives ~dst and leaves carry unchanged. Negate (12) gives 0−dst, and its carry_out is set exactly when dst is nonzero.
- R8: Increment (13) and decrement (14) wrap modulo 256 and leave carry_out equal to carry_in.
- R9: Clear (16) gives 0x00 and set-all (17) gives 0xFF, for any dst. Both leave carry unchanged.
- R10: Set-bits (18) gives dst OR imm. Clear-bits (19) gives dst AND NOT imm. Both leave carry unchanged.
- R11: Test (15) keeps `wr_en` low, presents dst on `result`, takes its zero and negative flags from dst, and leaves carry unchanged.
- R12: For every operation, `zero_out` is set when the 8-bit result is 0x00, and `neg_out` equals result bit 7.
- R13: Codes 20 to 31 are undefined. They keep `wr_en` low, present dst on `result`, take zero and negative from dst, and leave carry unchanged. All defined codes other than 15 raise `wr_en` with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select |
| dst_in | input | 8 | Destination operand |
| src_in | input | 8 | Source register operand |
| imm_in | input | 8 | Immediate constant or bit mask |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Results of an accepted operation are present |
| result | output | 8 | Byte to write back to the destination |
| wr_en | output | 1 | Write the result to the register file |
| carry_out | output | 1 | Updated carry flag |
| zero_out | output | 1 | Updated zero flag |
| neg_out | output | 1 | Updated negative flag |

## Verification
There is a single register stage. Every result, flag and write-enable for an operation accepted at one rising edge is due right after that edge, and it stays until the next edge. The bench drives inputs on falling edges. It lowers `op_valid` and then samples at the next falling edge, which is half a cycle after the outputs settle. Back-to-back operations are sampled one falling edge apart, so each check sees exactly one operation. The 16-bit chains take carry_out from the low byte and drive it as carry_in for the high byte one cycle later, which is the earliest cycle it is available.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_SUBI = 5'd4,
        OP_SBCI = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_ANDI = 5'd9,
        OP_ORI  = 5'd10,
        OP_COM  = 5'd11,
        OP_NEG  = 5'd12,
        OP_INC  = 5'd13,
        OP_DEC  = 5'd14,
        OP_TST  = 5'd15,
        OP_CLR  = 5'd16,
        OP_SER  = 5'd17,
        OP_SBR  = 5'd18,
        OP_CBR  = 5'd19
    } alu_op_e;

    // first operand source
    typedef enum logic {
        ASEL_DST  = 1'b0,
        ASEL_ZERO = 1'b1
    } a_sel_e;

    // second operand source
    typedef enum logic [1:0] {
        BSEL_SRC = 2'd0,
        BSEL_IMM = 2'd1,
        BSEL_DST = 2'd2,
        BSEL_ONE = 2'd3
    } b_sel_e;

    // adder carry-in source
    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2,
        CIN_NFLAG = 2'd3
    } cin_sel_e;

    typedef enum logic [2:0] {
        LF_AND  = 3'd0,
        LF_OR   = 3'd1,
        LF_XOR  = 3'd2,
        LF_ANDN = 3'd3,
        LF_NOTA = 3'd4,
        LF_ONES = 3'd5
    } logic_fn_e;

    typedef struct packed {
        logic      use_arith;
        a_sel_e    a_sel;
        b_sel_e    b_sel;
        logic      invert_b;
        cin_sel_e  cin_sel;
        logic_fn_e lfn;
        logic      carry_upd;
        logic      write;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c.use_arith = 1'b0;
        c.a_sel     = ASEL_DST;
        c.b_sel     = BSEL_DST;
        c.invert_b  = 1'b0;
        c.cin_sel   = CIN_ZERO;
        c.lfn       = LF_AND;
        c.carry_upd = 1'b0;
        c.write     = 1'b1;
        case (code)
            OP_ADD:  begin c.use_arith = 1'b1; c.b_sel = BSEL_SRC; c.carry_upd = 1'b1; end
            OP_ADC:  begin c.use_arith = 1'b1; c.b_sel = BSEL_SRC; c.cin_sel = CIN_FLAG;
                           c.carry_upd = 1'b1; end
            OP_SUB:  begin c.use_arith = 1'b1; c.b_sel = BSEL_SRC; c.invert_b = 1'b1;
                           c.cin_sel = CIN_ONE; c.carry_upd = 1'b1; end
            OP_SBC:  begin c.use_arith = 1'b1; c.b_sel = BSEL_SRC; c.invert_b = 1'b1;
                           c.cin_sel = CIN_NFLAG; c.carry_upd = 1'b1; end
            OP_SUBI: begin c.use_arith = 1'b1; c.b_sel = BSEL_IMM; c.invert_b = 1'b1;
                           c.cin_sel = CIN_ONE; c.carry_upd = 1'b1; end
            OP_SBCI: begin c.use_arith = 1'b1; c.b_sel = BSEL_IMM; c.invert_b = 1'b1;
                           c.cin_sel = CIN_NFLAG; c.carry_upd = 1'b1; end
            OP_AND:  begin c.b_sel = BSEL_SRC; c.lfn = LF_AND;  end
            OP_OR:   begin c.b_sel = BSEL_SRC; c.lfn = LF_OR;   end
            OP_XOR:  begin c.b_sel = BSEL_SRC; c.lfn = LF_XOR;  end
            OP_ANDI: begin c.b_sel = BSEL_IMM; c.lfn = LF_AND;  end
            OP_ORI:  begin c.b_sel = BSEL_IMM; c.lfn = LF_OR;   end
            OP_COM:  begin c.lfn = LF_NOTA; end
            OP_NEG:  begin c.use_arith = 1'b1; c.a_sel = ASEL_ZERO; c.b_sel = BSEL_DST;
                           c.invert_b = 1'b1; c.cin_sel = CIN_ONE; c.carry_upd = 1'b1; end
            OP_INC:  begin c.use_arith = 1'b1; c.b_sel = BSEL_ONE; end
            OP_DEC:  begin c.use_arith = 1'b1; c.b_sel = BSEL_ONE; c.invert_b = 1'b1;
                           c.cin_sel = CIN_ONE; end
            OP_TST:  begin c.b_sel = BSEL_DST; c.lfn = LF_AND; c.write = 1'b0; end
            OP_CLR:  begin c.b_sel = BSEL_DST; c.lfn = LF_XOR; end
            OP_SER:  begin c.lfn = LF_ONES; end
            OP_SBR:  begin c.b_sel = BSEL_IMM; c.lfn = LF_OR;   end
            OP_CBR:  begin c.b_sel = BSEL_IMM; c.lfn = LF_ANDN; end
            default: begin c.write = 1'b0; end
        endcase
        return c;
    endfunction

    function automatic logic pick_cin(input cin_sel_e sel, input logic flag);
        case (sel)
            CIN_ONE:   return 1'b1;
            CIN_FLAG:  return flag;
            CIN_NFLAG: return ~flag;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output alu_ctrl_t       ctrl
);
    always_comb begin
        ctrl = decode_op(op_code);
    end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] bx;
    logic [WIDTH:0]   chain;

    assign bx       = b ^ {WIDTH{invert_b}};
    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic p;
        assign p          = a[i] ^ bx[i];
        assign sum[i]     = p ^ chain[i];
        assign chain[i+1] = (a[i] & bx[i]) | (chain[i] & p);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            LF_ANDN: y = a & ~b;
            LF_NOTA: y = ~a;
            LF_ONES: y = {WIDTH{1'b1}};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/byte_alu_unit.sv
module byte_alu_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [4:0]       op_code,
    input  logic [WIDTH-1:0] dst_in,
    input  logic [WIDTH-1:0] src_in,
    input  logic [WIDTH-1:0] imm_in,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             carry_out,
    output logic             zero_out,
    output logic             neg_out
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] opa, opb;
    logic [WIDTH-1:0] sum_w, logic_w, res_d;
    logic             cout_w, cin_w, carry_d;

    alu8_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    always_comb begin
        opa = (ctrl.a_sel == ASEL_ZERO) ? '0 : dst_in;
        case (ctrl.b_sel)
            BSEL_SRC: opb = src_in;
            BSEL_IMM: opb = imm_in;
            BSEL_ONE: opb = ONE_W;
            default:  opb = dst_in;
        endcase
        cin_w = pick_cin(ctrl.cin_sel, carry_in);
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_add (
        .a        (opa),
        .b        (opb),
        .invert_b (ctrl.invert_b),
        .cin      (cin_w),
        .sum      (sum_w),
        .cout     (cout_w)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_lgc (
        .a  (opa),
        .b  (opb),
        .fn (ctrl.lfn),
        .y  (logic_w)
    );

    always_comb begin
        res_d = ctrl.use_arith ? sum_w : logic_w;
        // subtract forms report borrow, which is the inverted adder carry
        if (ctrl.carry_upd) carry_d = ctrl.invert_b ? ~cout_w : cout_w;
        else                carry_d = carry_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            zero_out  <= 1'b0;
            neg_out   <= 1'b0;
        end else begin
            out_valid <= op_valid;
            wr_en     <= op_valid & ctrl.write;
            if (op_valid) begin
                result    <= res_d;
                carry_out <= carry_d;
                zero_out  <= (res_d == '0);
                neg_out   <= res_d[MSB];
            end
        end
    end
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [4:0]       op_code,
    input logic [WIDTH-1:0] dst_in,
    input logic             carry_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic             carry_out,
    input logic             zero_out,
    input logic             neg_out
);
    localparam int MSB = WIDTH - 1;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!out_valid && !wr_en && $stable(result) && $stable(carry_out)));

    assert_logic_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 5'd6 && op_code <= 5'd10) |=> (carry_out == $past(carry_in)));

    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 5'd13 || op_code == 5'd14)) |=> (carry_out == $past(carry_in)));

    assert_clr_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 5'd16) |=> (result == '0 && zero_out && !neg_out && wr_en));

    assert_ser_ones_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 5'd17) |=> (result == {WIDTH{1'b1}} && neg_out && !zero_out));

    assert_tst_nowrite_R11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 5'd15) |=> (!wr_en && result == $past(dst_in)));

    assert_flag_track_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zero_out == (result == '0) && neg_out == result[MSB]));

    assert_undef_nowrite_R13: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 5'd20) |=> (!wr_en && carry_out == $past(carry_in)));
endmodule

bind byte_alu_unit alu8_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .dst_in    (dst_in),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .neg_out   (neg_out)
);

// File: tb/sim_byte_alu_unit.sv
module sim_byte_alu_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [4:0] op_code;
    logic [7:0] dst_in, src_in, imm_in;
    logic       carry_in;
    logic       out_valid, wr_en, carry_out, zero_out, neg_out;
    logic [7:0] result;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    byte_alu_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dst_in(dst_in), .src_in(src_in), .imm_in(imm_in), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .carry_out(carry_out), .zero_out(zero_out), .neg_out(neg_out)
    );

    // {code, dst, src, imm, carry_in, expected result, expected wr_en, expected carry}
    localparam int NV = 28;
    localparam logic [39:0] VEC [NV] = '{
        {5'd0,  8'h3C, 8'h4A, 8'h00, 1'b1, 8'h86, 1'b1, 1'b0},
        {5'd0,  8'hF0, 8'h20, 8'h00, 1'b0, 8'h10, 1'b1, 1'b1},
        {5'd1,  8'h7F, 8'h80, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1},
        {5'd1,  8'h12, 8'h34, 8'h00, 1'b0, 8'h46, 1'b1, 1'b0},
        {5'd2,  8'h50, 8'h30, 8'h00, 1'b1, 8'h20, 1'b1, 1'b0},
        {5'd2,  8'h10, 8'h20, 8'h00, 1'b0, 8'hF0, 1'b1, 1'b1},
        {5'd3,  8'h00, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1},
        {5'd3,  8'h44, 8'h20, 8'h00, 1'b1, 8'h23, 1'b1, 1'b0},
        {5'd4,  8'h80, 8'hFF, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b0},
        {5'd5,  8'h05, 8'h00, 8'h05, 1'b1, 8'hFF, 1'b1, 1'b1},
        {5'd6,  8'hA5, 8'h0F, 8'hFF, 1'b1, 8'h05, 1'b1, 1'b1},
        {5'd7,  8'hA0, 8'h05, 8'h00, 1'b0, 8'hA5, 1'b1, 1'b0},
        {5'd8,  8'hFF, 8'h0F, 8'h00, 1'b1, 8'hF0, 1'b1, 1'b1},
        {5'd9,  8'h3C, 8'h00, 8'hF0, 1'b0, 8'h30, 1'b1, 1'b0},
        {5'd10, 8'h01, 8'h00, 8'h80, 1'b1, 8'h81, 1'b1, 1'b1},
        {5'd11, 8'h55, 8'h00, 8'h00, 1'b0, 8'hAA, 1'b1, 1'b0},
        {5'd12, 8'h01, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b1},
        {5'd12, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},
        {5'd12, 8'h80, 8'h00, 8'h00, 1'b0, 8'h80, 1'b1, 1'b1},
        {5'd13, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1},
        {5'd14, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0},
        {5'd14, 8'h80, 8'h00, 8'h00, 1'b1, 8'h7F, 1'b1, 1'b1},
        {5'd15, 8'h80, 8'h11, 8'h22, 1'b1, 8'h80, 1'b0, 1'b1},
        {5'd16, 8'h9E, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0},
        {5'd17, 8'h00, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1},
        {5'd18, 8'h10, 8'h00, 8'h04, 1'b0, 8'h14, 1'b1, 1'b0},
        {5'd19, 8'hFF, 8'h00, 8'h04, 1'b0, 8'hFB, 1'b1, 1'b0},
        {5'd31, 8'h3C, 8'h55, 8'hAA, 1'b1, 8'h3C, 1'b0, 1'b1}
    };

    function automatic string req_of(input logic [4:0] c);
        case (c)
            5'd0, 5'd1:                      return "R3";
            5'd2, 5'd3:                      return "R4";
            5'd4, 5'd5:                      return "R5";
            5'd6, 5'd7, 5'd8, 5'd9, 5'd10:   return "R6";
            5'd11, 5'd12:                    return "R7";
            5'd13, 5'd14:                    return "R8";
            5'd15:                           return "R11";
            5'd16, 5'd17:                    return "R9";
            5'd18, 5'd19:                    return "R10";
            default:                         return "R13";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one operation on a falling edge, sample its results one cycle later
    task automatic run_op(input logic [4:0] c, input logic [7:0] d, input logic [7:0] s,
                          input logic [7:0] k, input logic ci);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; dst_in = d; src_in = s; imm_in = k; carry_in = ci;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] lo, hi;
        logic       cc;
        rst = 1'b1; op_valid = 1'b1; op_code = 5'd17; dst_in = 8'h00;
        src_in = 8'h00; imm_in = 8'h00; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        // R2: reset wins over a pending set-all
        check("R2", "reset outputs", {26'd0, out_valid, wr_en, carry_out, zero_out, neg_out, |result},
              32'd0);
        rst = 1'b0; op_valid = 1'b0;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [4:0] c;  logic [7:0] d, s, k, er; logic ci, ew, ec;
            {c, d, s, k, ci, er, ew, ec} = VEC[i];
            run_op(c, d, s, k, ci);
            check(req_of(c), $sformatf("vector %0d result/we/carry/valid", i),
                  {21'd0, result, wr_en, carry_out, out_valid},
                  {21'd0, er, ew, ec, 1'b1});
            check("R12", $sformatf("vector %0d zero/neg", i),
                  {30'd0, zero_out, neg_out}, {30'd0, (er == 8'h00), er[7]});
        end

        // R1: idle cycles hold result and flags, drop valid and write
        run_op(5'd0, 8'h01, 8'h02, 8'h00, 1'b0);
        dst_in = 8'hEE; src_in = 8'h77;
        @(negedge clk);
        check("R1", "idle hold", {22'd0, result, out_valid, wr_en},
              {22'd0, 8'h03, 1'b0, 1'b0});
        @(negedge clk);
        check("R1", "idle hold 2nd cycle", {29'd0, carry_out, zero_out, neg_out}, 32'd0);

        // R1: back-to-back operations, one per cycle
        @(negedge clk);
        op_valid = 1'b1; op_code = 5'd13; dst_in = 8'h41; carry_in = 1'b0;
        @(negedge clk);
        check("R1", "back-to-back first", {23'd0, result, out_valid}, {23'd0, 8'h42, 1'b1});
        op_code = 5'd14; dst_in = 8'h01;
        @(negedge clk);
        op_valid = 1'b0;
        check("R1", "back-to-back second", {22'd0, result, out_valid, zero_out},
              {22'd0, 8'h00, 1'b1, 1'b1});

        // R4: 16-bit chain 0x1234 - 0x0235 = 0x0FFF
        run_op(5'd2, 8'h34, 8'h35, 8'h00, 1'b0);
        lo = result; cc = carry_out;
        run_op(5'd3, 8'h12, 8'h02, 8'h00, cc);
        hi = result;
        check("R4", "16-bit subtract chain", {16'd0, hi, lo}, 32'h0FFF);

        // R5: 16-bit immediate chain 0x4420 - 0x0021 = 0x43FF
        run_op(5'd4, 8'h20, 8'h00, 8'h21, 1'b0);
        lo = result; cc = carry_out;
        run_op(5'd5, 8'h44, 8'h00, 8'h00, cc);
        hi = result;
        check("R5", "16-bit immediate chain", {16'd0, hi, lo}, 32'h43FF);

        // R3: 16-bit add chain 0x00FF + 0x0001 = 0x0100
        run_op(5'd0, 8'hFF, 8'h01, 8'h00, 1'b0);
        lo = result; cc = carry_out;
        run_op(5'd1, 8'h00, 8'h00, 8'h00, cc);
        hi = result;
        check("R3", "16-bit add chain", {15'd0, carry_out, hi, lo}, 32'h0100);

        // R13: undefined code 20 does not write and keeps carry low
        run_op(5'd20, 8'h00, 8'hFF, 8'hFF, 1'b0);
        check("R13", "code 20", {21'd0, result, wr_en, carry_out, zero_out},
              {21'd0, 8'h00, 1'b0, 1'b0, 1'b1});

        // R2: reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b1; op_code = 5'd17;
        @(negedge clk);
        rst = 1'b0; op_valid = 1'b0;
        check("R2", "mid-run reset", {24'd0, result}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule